// File: doc/BRIEF.md
# Page-Range Invalidation Register Slice

This block is the register-side front end of a memory protection unit's lookup cache invalidation path. Software programs a first and a last page number into two holding registers and then writes a command register. The block turns that command into a single-cycle request to the lookup cache. The request carries an inclusive range of page numbers. A page number is a byte address shifted right by 12, so one page is 4 KiB.

A second command register asks the cache to drop every entry. The two commands share one outstanding slot. From the cycle a request is issued until the cache returns its acknowledge strobe, the block reports busy and ignores further commands. If the programmed range is empty, meaning the first page is above the last page, the command completes at once. In that case no request reaches the cache.

Accesses use a simple single-cycle read/write bus. Read data appears registered, one cycle after the access.

Top module: `mpu_inval_regs`

## Requirements
- R1: After reset both cache request outputs are low, busy reads 0, and the first-page and last-page registers read 0.
- R2: A write to offset 0x1024 loads the first-page register and a write to 0x1028 loads the last-page register. Each keeps the low PW bits of the write data and reads back zero-extended.
- R3: Writing 1 in bit 0 of offset 0x1020 while idle, with first <= last, raises the range request for exactly one cycle, starting in the cycle after the write. During that cycle the low and high outputs equal the first-page and last-page register values.
- R4: Writing 1 in bit 0 of offset 0x1000 while idle raises the whole-table request for exactly one cycle, starting in the cycle after the write. It is never raised together with the range request.
- R5: Busy rises together with any request pulse and reads back in bit 1 of both 0x1000 and 0x1020. It falls in the cycle after the acknowledge is sampled high. An acknowledge while idle has no effect.
- R6: A command write to either command register while busy produces no request and leaves the holding registers' read values unchanged.
- R7: A range command with first > last produces no request and leaves busy at 0.
- R8: A write to a command register with bit 0 clear produces no request.
- R9: The range is inclusive: first equal to last issues a request whose low and high outputs are both that page.
- R10: Read data and its valid flag appear in the cycle after a read. A read of any offset other than the four above returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_vld | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW (16) | Byte offset of the access |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, one cycle after the read |
| bus_rvld | output | 1 | Read data valid |
| cache_flush_all | output | 1 | One-cycle whole-table invalidate request |
| cache_flush_rng | output | 1 | One-cycle range invalidate request |
| cache_pn_lo | output | PW (20) | First page of the range, valid with cache_flush_rng |
| cache_pn_hi | output | PW (20) | Last page of the range (inclusive), valid with cache_flush_rng |
| cache_ack | input | 1 | Acknowledge strobe from the lookup cache |

## Verification
The properties assume at most one bus access per cycle and treat the acknowledge as a strobe that matters only while a request is outstanding. Under those assumptions they check three things: a request pulse never lasts two cycles, no new pulse appears while the slot is held, and an acknowledged slot frees on the next edge. The stimulus raises the acknowledge for a single cycle, only after it has seen a pulse. It also issues one deliberately stray acknowledge while idle to confirm it is harmless. Every command written while busy comes between the pulse and that acknowledge.

// File: rtl/mpu_inval_pkg.sv
package mpu_inval_pkg;

    localparam logic [15:0] OFS_FLUSH_ALL = 16'h1000;
    localparam logic [15:0] OFS_FLUSH_RNG = 16'h1020;
    localparam logic [15:0] OFS_PN_FIRST  = 16'h1024;
    localparam logic [15:0] OFS_PN_LAST   = 16'h1028;

    localparam int CMD_BIT  = 0;
    localparam int BUSY_BIT = 1;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_ALL   = 2'd1,
        CMD_RANGE = 2'd2
    } inval_cmd_e;

endpackage

// File: rtl/mpu_inval_decode.sv
module mpu_inval_decode
    import mpu_inval_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_vld,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          busy,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_rvld,
    output logic [PW-1:0] pn_first,
    output logic [PW-1:0] pn_last,
    output inval_cmd_e    cmd
);

    localparam int PADW = DW - PW;

    typedef struct packed {
        logic [PW-1:0] first;
        logic [PW-1:0] last;
        logic [DW-1:0] rdata;
        logic          rvld;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic hit_all, hit_rng, hit_first, hit_last;
    logic wr_en, rd_en;
    logic [DW-1:0] status_word;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DW-1:PW];

    always_comb begin
        hit_all   = (bus_addr == AW'(OFS_FLUSH_ALL));
        hit_rng   = (bus_addr == AW'(OFS_FLUSH_RNG));
        hit_first = (bus_addr == AW'(OFS_PN_FIRST));
        hit_last  = (bus_addr == AW'(OFS_PN_LAST));
        wr_en     = bus_vld && bus_wr;
        rd_en     = bus_vld && !bus_wr;

        status_word           = '0;
        status_word[BUSY_BIT] = busy;

        cmd = CMD_NONE;
        if (wr_en && bus_wdata[CMD_BIT]) begin
            if (hit_all) begin
                cmd = CMD_ALL;
            end else if (hit_rng) begin
                cmd = CMD_RANGE;
            end
        end

        st_d      = st_q;
        st_d.rvld = rd_en;
        if (wr_en && hit_first) begin
            st_d.first = bus_wdata[PW-1:0];
        end
        if (wr_en && hit_last) begin
            st_d.last = bus_wdata[PW-1:0];
        end
        if (rd_en) begin
            if (hit_all || hit_rng) begin
                st_d.rdata = status_word;
            end else if (hit_first) begin
                st_d.rdata = {{PADW{1'b0}}, st_q.first};
            end else if (hit_last) begin
                st_d.rdata = {{PADW{1'b0}}, st_q.last};
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pn_first  = st_q.first;
    assign pn_last   = st_q.last;
    assign bus_rdata = st_q.rdata;
    assign bus_rvld  = st_q.rvld;

endmodule

// File: rtl/mpu_inval_seq.sv
module mpu_inval_seq
    import mpu_inval_pkg::*;
#(
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  inval_cmd_e    cmd,
    input  logic [PW-1:0] pn_first,
    input  logic [PW-1:0] pn_last,
    input  logic          ack,
    output logic          flush_all,
    output logic          flush_rng,
    output logic [PW-1:0] pn_lo,
    output logic [PW-1:0] pn_hi,
    output logic          busy
);

    typedef struct packed {
        logic          busy;
        logic          all;
        logic          rng;
        logic [PW-1:0] lo;
        logic [PW-1:0] hi;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic range_ok;

    always_comb begin
        range_ok = (pn_first <= pn_last);

        st_d     = st_q;
        st_d.all = 1'b0;
        st_d.rng = 1'b0;

        if (st_q.busy) begin
            if (ack) begin
                st_d.busy = 1'b0;
            end
        end else begin
            unique case (cmd)
                CMD_ALL: begin
                    st_d.all  = 1'b1;
                    st_d.busy = 1'b1;
                end
                CMD_RANGE: begin
                    if (range_ok) begin
                        st_d.rng  = 1'b1;
                        st_d.busy = 1'b1;
                        st_d.lo   = pn_first;
                        st_d.hi   = pn_last;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flush_all = st_q.all;
    assign flush_rng = st_q.rng;
    assign pn_lo     = st_q.lo;
    assign pn_hi     = st_q.hi;
    assign busy      = st_q.busy;

endmodule

// File: rtl/mpu_inval_regs.sv
module mpu_inval_regs
    import mpu_inval_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_vld,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_rvld,
    output logic          cache_flush_all,
    output logic          cache_flush_rng,
    output logic [PW-1:0] cache_pn_lo,
    output logic [PW-1:0] cache_pn_hi,
    input  logic          cache_ack
);

    logic          busy;
    logic [PW-1:0] pn_first;
    logic [PW-1:0] pn_last;
    inval_cmd_e    cmd;

    mpu_inval_decode #(.AW(AW), .DW(DW), .PW(PW)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_vld   (bus_vld),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .bus_rdata (bus_rdata),
        .bus_rvld  (bus_rvld),
        .pn_first  (pn_first),
        .pn_last   (pn_last),
        .cmd       (cmd)
    );

    mpu_inval_seq #(.PW(PW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .pn_first  (pn_first),
        .pn_last   (pn_last),
        .ack       (cache_ack),
        .flush_all (cache_flush_all),
        .flush_rng (cache_flush_rng),
        .pn_lo     (cache_pn_lo),
        .pn_hi     (cache_pn_hi),
        .busy      (busy)
    );

endmodule

// File: rtl/mpu_inval_chk.sv
module mpu_inval_chk #(
    parameter int PW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush_all,
    input logic          flush_rng,
    input logic [PW-1:0] pn_lo,
    input logic [PW-1:0] pn_hi,
    input logic          ack,
    input logic          busy
);

    AST_RNG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_rng |=> !flush_rng);  // R3

    AST_ALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !flush_all);  // R4

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_all && flush_rng));  // R4

    AST_PULSE_HOLDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all || flush_rng) |-> busy);  // R5

    AST_ACK_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ack) |=> !busy);  // R5

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack) |=> (busy && !flush_all && !flush_rng));  // R6

    AST_RANGE_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        flush_rng |-> (pn_lo <= pn_hi));  // R7

endmodule

bind mpu_inval_regs mpu_inval_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_all (cache_flush_all),
    .flush_rng (cache_flush_rng),
    .pn_lo     (cache_pn_lo),
    .pn_hi     (cache_pn_hi),
    .ack       (cache_ack),
    .busy      (busy)
);

// File: tb/mpu_inval_regs_test.sv
module mpu_inval_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int PW = 20;

    localparam logic [15:0] A_ALL   = 16'h1000;
    localparam logic [15:0] A_RNG   = 16'h1020;
    localparam logic [15:0] A_FIRST = 16'h1024;
    localparam logic [15:0] A_LAST  = 16'h1028;

    typedef struct packed {
        logic          all;
        logic [PW-1:0] lo;
        logic [PW-1:0] hi;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_vld = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_rvld;
    logic          cache_flush_all;
    logic          cache_flush_rng;
    logic [PW-1:0] cache_pn_lo;
    logic [PW-1:0] cache_pn_hi;
    logic          cache_ack = 1'b0;

    int   n_checks = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mpu_inval_regs #(.AW(AW), .DW(DW), .PW(PW)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_vld         (bus_vld),
        .bus_wr          (bus_wr),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .bus_rvld        (bus_rvld),
        .cache_flush_all (cache_flush_all),
        .cache_flush_rng (cache_flush_rng),
        .cache_pn_lo     (cache_pn_lo),
        .cache_pn_hi     (cache_pn_hi),
        .cache_ack       (cache_ack)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_vld = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_vld = 1'b0;
        check(bus_rvld === 1'b1, "R10 read valid", bus_rvld, 1);
        d = bus_rdata;
    endtask

    task automatic give_ack();
        @(negedge clk);
        cache_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cache_ack = 1'b0;
    endtask

    task automatic expect_pulse(input logic all, input logic [PW-1:0] lo, input logic [PW-1:0] hi);
        exp_t e;
        e.all = all; e.lo = lo; e.hi = hi;
        exp_q.push_back(e);
    endtask

    // monitor: every pulse cycle must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && (cache_flush_all || cache_flush_rng)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6/R7/R8 unexpected request", {cache_flush_all, cache_flush_rng}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.all) begin
                    check(cache_flush_all && !cache_flush_rng, "R4 whole-table pulse",
                          {cache_flush_all, cache_flush_rng}, 2'b10);
                end else begin
                    check(cache_flush_rng && !cache_flush_all, "R3 range pulse kind",
                          {cache_flush_all, cache_flush_rng}, 2'b01);
                    check(cache_pn_lo == e.lo, "R3/R9 range low", cache_pn_lo, e.lo);
                    check(cache_pn_hi == e.hi, "R3/R9 range high", cache_pn_hi, e.hi);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(!cache_flush_all && !cache_flush_rng, "R1 no request after reset",
              {cache_flush_all, cache_flush_rng}, 0);
        check(bus_rvld == 1'b0, "R1 no read valid", bus_rvld, 0);
        bus_read(A_FIRST, rd); check(rd == 0, "R1 first reg", rd, 0);
        bus_read(A_LAST, rd);  check(rd == 0, "R1 last reg", rd, 0);
        bus_read(A_RNG, rd);   check(rd[1] == 1'b0, "R1 busy clear", rd, 0);

        // R2 holding registers
        bus_write(A_FIRST, 32'hFFFF_FFFF);
        bus_read(A_FIRST, rd); check(rd == 32'h000F_FFFF, "R2 first masked", rd, 32'h000F_FFFF);
        bus_write(A_FIRST, 32'd5);
        bus_write(A_LAST, 32'd9);
        bus_read(A_FIRST, rd); check(rd == 5, "R2 first value", rd, 5);
        bus_read(A_LAST, rd);  check(rd == 9, "R2 last value", rd, 9);

        // R3 range request, R5 busy, R6 commands ignored while busy
        expect_pulse(1'b0, 20'd5, 20'd9);
        bus_write(A_RNG, 32'h1);
        bus_read(A_RNG, rd); check(rd[1] == 1'b1, "R5 busy at range reg", rd, 2);
        bus_read(A_ALL, rd); check(rd[1] == 1'b1, "R5 busy at whole reg", rd, 2);
        bus_write(A_RNG, 32'h1);
        bus_write(A_ALL, 32'h1);
        bus_read(A_FIRST, rd); check(rd == 5, "R6 first unchanged", rd, 5);
        bus_read(A_LAST, rd);  check(rd == 9, "R6 last unchanged", rd, 9);
        give_ack();
        bus_read(A_RNG, rd); check(rd[1] == 1'b0, "R5 busy freed", rd, 0);
        check(exp_q.size() == 0, "R3 range pulse seen", exp_q.size(), 0);

        // R5 stray acknowledge while idle
        give_ack();
        bus_read(A_ALL, rd); check(rd[1] == 1'b0, "R5 idle ack ignored", rd, 0);

        // R4 whole-table request
        expect_pulse(1'b1, '0, '0);
        bus_write(A_ALL, 32'h1);
        bus_read(A_ALL, rd); check(rd[1] == 1'b1, "R4 busy after whole-table", rd, 2);
        give_ack();
        check(exp_q.size() == 0, "R4 whole-table pulse seen", exp_q.size(), 0);

        // R8 bit 0 clear
        bus_write(A_RNG, 32'h2);
        bus_write(A_ALL, 32'hFFFF_FFFE);
        bus_read(A_RNG, rd); check(rd[1] == 1'b0, "R8 no busy", rd, 0);

        // R7 empty range
        bus_write(A_FIRST, 32'd10);
        bus_write(A_LAST, 32'd3);
        bus_write(A_RNG, 32'h1);
        bus_read(A_RNG, rd); check(rd[1] == 1'b0, "R7 empty stays idle", rd, 0);

        // R9 single page, top page
        bus_write(A_FIRST, 32'h000F_FFFF);
        bus_write(A_LAST, 32'h000F_FFFF);
        expect_pulse(1'b0, 20'hFFFFF, 20'hFFFFF);
        bus_write(A_RNG, 32'h1);
        give_ack();
        check(exp_q.size() == 0, "R9 single page pulse seen", exp_q.size(), 0);

        // R10 unmapped offsets
        bus_read(16'h1004, rd); check(rd == 0, "R10 unmapped 0x1004", rd, 0);
        bus_read(16'h0000, rd); check(rd == 0, "R10 unmapped 0x0000", rd, 0);
        @(negedge clk);
        check(bus_rvld == 1'b0, "R10 valid drops", bus_rvld, 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule